// File: doc/BRIEF.md
# Power Management Event Register Block

This block holds the power-event registers that system software polls and programs: a 16-bit event status word, a 16-bit event enable word, a 16-bit control word and a free-running up-counter used as a power-management timer. Its one output to the interrupt controller is a level-sensitive system control interrupt (SCI). SCI is high while an enabled status bit in one of four event classes is set, or while the hot-plug bit of a small general-purpose event (GPE) register pair is both pending and enabled.

The register set is reached through a simple I/O port. A 64-byte window in that port's address space holds it, and configuration bytes set the window's base and turn its decode on. The GPE pair sits at a fixed I/O address given by a parameter. A byte-wide management command port moves the control word's SCI-mode bit between its two states. Every write to the command port can also give a one-cycle SMI pulse, if a configuration bit allows it. Event sources reach the block as single-cycle request pulses: the power button, a 16-bit generic event vector and a hot-plug request.

The I/O, configuration and command ports have no back-pressure. Each access is taken in the cycle in which it is presented. Reads return data combinationally in the same cycle, and writes take effect at the next rising clock edge. No ready signal exists because no access can stall.

Top module: `pm_evt_regs`

## Requirements
- R1: The window base is {cfg byte 0x41, cfg byte 0x40 bits 7:6, six zero bits}, so the window spans 64 bytes. Accesses decode only while cfg byte 0x80 bit 0 is 1. Outside the window, or while decode is off, reads return 0 and writes change nothing.
- R2: Cfg byte 0x40 reads back with bits 7:6 as stored, bits 5:1 as 0 and bit 0 always 1, whatever was written. Byte 0x41 reads back in full. Byte 0x80 keeps only bit 0 and byte 0x5B keeps only bit 1. Every other cfg byte reads 0.
- R3: The window offsets are 0x00 status, 0x02 enable, 0x04 control and 0x08 timer, with the timer zero-extended to 32 bits. Reads of any other offset return 0.
- R4: Status bits are write-one-to-clear, and writing 0 to a bit leaves it unchanged. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R5: SCI is high exactly when (status AND enable) has any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (RTC) set, or when GPE status bit 1 and GPE enable bit 1 are both set. Other bits never raise SCI.
- R6: GPE status is a write-one-to-clear word at I/O address GPE_BASE and GPE enable is a read/write word at GPE_BASE+2. This pair decodes regardless of the cfg enable bit. A hot-plug request sets GPE status bit 1.
- R7: A power-button request sets status bit 8, and generic event request bit i sets status bit i.
- R8: The timer adds 1 every clock and wraps modulo 2^TMR_W.
- R9: When the timer MSB toggles, status bit 0 sets only if timer checking is armed. It is armed when enable bit 0 is 1 and status bit 0 is 0.
- R10: A command write of 0xF1 sets control bit 0 and a write of 0xF0 clears it. Other command values leave the control word unchanged. A command wins over an I/O write to control bit 0 in the same cycle.
- R11: SMI is high for exactly one cycle after each command write while cfg byte 0x5B bit 1 is 1. It stays low otherwise.
- R12: A synchronous reset clears status, enable, control, GPE registers, cfg bytes and the timer, and drives SCI and SMI low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | I/O access presented this cycle |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 32 | I/O read data (0 when no read is decoded) |
| cfg_we | input | 1 | Configuration byte write |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr |
| cmd_we | input | 1 | Management command write strobe |
| cmd_data | input | 8 | Management command value |
| pwrbtn_req | input | 1 | Power-button event pulse |
| evt_req | input | 16 | Generic status-set pulses, one per status bit |
| hp_req | input | 1 | Hot-plug event pulse |
| sci | output | 1 | System control interrupt level |
| smi | output | 1 | One-cycle SMI pulse |

## Verification
The central test crosses every single status bit with every single enable bit, 256 pairs in all. SCI is predicted from the status value read back and the bench's own class mask, which separates the four SCI-capable classes from the twelve that must stay silent. Patterns with several bits set are used next: a selective clear of one of two pending bits, and a set and a clear of the same bit in one cycle. Together they tell the write-one-to-clear behaviour apart from a plain overwrite and from a clear that wins. The timer runs with checking disarmed and then armed, which shows whether the MSB toggle is gated. Command values 0xF1, 0xF0 and an unrelated value are each sent with SMI permission off and on, to separate the mode change from the pulse.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned EVT_W   = 16;
  localparam int unsigned IO_AW   = 16;
  localparam int unsigned WIN_W   = 6;
  localparam int unsigned RD_W    = 32;
  localparam int unsigned BASE_HW = IO_AW - WIN_W;

  localparam int unsigned TMR_BIT = 0;
  localparam int unsigned GBL_BIT = 5;
  localparam int unsigned PWR_BIT = 8;
  localparam int unsigned RTC_BIT = 10;
  localparam int unsigned HP_BIT  = 1;

  localparam logic [EVT_W-1:0] SCI_MASK =
    EVT_W'((1 << TMR_BIT) | (1 << GBL_BIT) | (1 << PWR_BIT) | (1 << RTC_BIT));

  localparam logic [7:0] CMD_MODE_ON  = 8'hF1;
  localparam logic [7:0] CMD_MODE_OFF = 8'hF0;

  localparam logic [7:0] CFG_BASE_LO = 8'h40;
  localparam logic [7:0] CFG_BASE_HI = 8'h41;
  localparam logic [7:0] CFG_DEC_EN  = 8'h80;
  localparam logic [7:0] CFG_SMM     = 8'h5B;

  localparam logic [WIN_W-1:0] OFS_STS = 6'h00;
  localparam logic [WIN_W-1:0] OFS_EN  = 6'h02;
  localparam logic [WIN_W-1:0] OFS_CTL = 6'h04;
  localparam logic [WIN_W-1:0] OFS_TMR = 6'h08;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_STS  = 3'd1,
    SEL_EN   = 3'd2,
    SEL_CTL  = 3'd3,
    SEL_TMR  = 3'd4
  } pm_sel_e;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
  import pm_evt_pkg::*;
#(
  parameter int unsigned AW = IO_AW,
  parameter int unsigned WW = WIN_W
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-WW-1:0] base_hi,
  input  logic             dec_on,
  output logic             hit,
  output pm_sel_e          sel
);
  logic [WW-1:0] ofs;

  assign ofs = addr[WW-1:0];
  assign hit = dec_on && (addr[AW-1:WW] == base_hi);

  always_comb begin
    sel = SEL_NONE;
    if (hit) begin
      unique case (ofs)
        OFS_STS: sel = SEL_STS;
        OFS_EN:  sel = SEL_EN;
        OFS_CTL: sel = SEL_CTL;
        OFS_TMR: sel = SEL_TMR;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count,
  output logic         msb_flip
);
  logic msb_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      msb_seen <= 1'b0;
    end else begin
      count    <= count + W'(1);
      msb_seen <= count[W-1];
    end
  end

  assign msb_flip = msb_seen ^ count[W-1];
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen
  import pm_evt_pkg::*;
#(
  parameter int unsigned DW = EVT_W
) (
  input  logic [DW-1:0] sts,
  input  logic [DW-1:0] en,
  input  logic [DW-1:0] gsts,
  input  logic [DW-1:0] gen,
  output logic          sci
);
  logic pm_hit;
  logic gp_hit;

  assign pm_hit = |(sts & en & DW'(SCI_MASK));
  assign gp_hit = gsts[HP_BIT] & gen[HP_BIT];
  assign sci    = pm_hit | gp_hit;
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int unsigned      TMR_W    = 24,
  parameter logic [IO_AW-1:0] GPE_BASE = 16'hAFE0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_valid,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [EVT_W-1:0] io_wdata,
  output logic [RD_W-1:0]  io_rdata,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_data,
  input  logic             pwrbtn_req,
  input  logic [EVT_W-1:0] evt_req,
  input  logic             hp_req,
  output logic             sci,
  output logic             smi
);
  localparam logic [IO_AW-1:0] GPE_EN_ADDR = GPE_BASE + IO_AW'(2);

  logic [EVT_W-1:0] sts_q, en_q, ctl_q, gsts_q, gen_q;
  logic [1:0]       cfg_b0_q;
  logic [7:0]       cfg_b1_q;
  logic             cfg_dec_q, cfg_smm_q, smi_q;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_flip;
  logic             win_hit;
  pm_sel_e          win_sel;
  logic             io_wr, io_rd;
  logic             wr_sts, wr_en, wr_ctl, wr_gsts, wr_gen;
  logic             tmr_armed;
  logic [EVT_W-1:0] sts_set, sts_clr, gsts_set, gsts_clr;
  logic [EVT_W-1:0] ctl_d;
  logic [RD_W-1:0]  win_rd, gpe_rd;

  pm_win_decode #(.AW(IO_AW), .WW(WIN_W)) u_dec (
    .addr    (io_addr),
    .base_hi ({cfg_b1_q, cfg_b0_q}),
    .dec_on  (cfg_dec_q),
    .hit     (win_hit),
    .sel     (win_sel)
  );

  pm_tmr #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .count    (tmr_val),
    .msb_flip (tmr_flip)
  );

  pm_sci_gen #(.DW(EVT_W)) u_sci (
    .sts  (sts_q),
    .en   (en_q),
    .gsts (gsts_q),
    .gen  (gen_q),
    .sci  (sci)
  );

  assign io_wr   = io_valid & io_we;
  assign io_rd   = io_valid & ~io_we;
  assign wr_sts  = io_wr & (win_sel == SEL_STS);
  assign wr_en   = io_wr & (win_sel == SEL_EN);
  assign wr_ctl  = io_wr & (win_sel == SEL_CTL);
  assign wr_gsts = io_wr & (io_addr == GPE_BASE);
  assign wr_gen  = io_wr & (io_addr == GPE_EN_ADDR);

  // Timer checking is live only while enabled and not already pending.
  assign tmr_armed = en_q[TMR_BIT] & ~sts_q[TMR_BIT];

  always_comb begin
    sts_set = evt_req;
    sts_set[PWR_BIT] = sts_set[PWR_BIT] | pwrbtn_req;
    sts_set[TMR_BIT] = sts_set[TMR_BIT] | (tmr_flip & tmr_armed);
    sts_clr  = wr_sts ? io_wdata : '0;
    gsts_set = '0;
    gsts_set[HP_BIT] = hp_req;
    gsts_clr = wr_gsts ? io_wdata : '0;
  end

  always_comb begin
    ctl_d = wr_ctl ? io_wdata : ctl_q;
    if (cmd_we && cmd_data == CMD_MODE_ON)  ctl_d[0] = 1'b1;
    if (cmd_we && cmd_data == CMD_MODE_OFF) ctl_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      en_q   <= '0;
      ctl_q  <= '0;
      gsts_q <= '0;
      gen_q  <= '0;
      smi_q  <= 1'b0;
    end else begin
      sts_q  <= (sts_q & ~sts_clr) | sts_set;
      gsts_q <= (gsts_q & ~gsts_clr) | gsts_set;
      ctl_q  <= ctl_d;
      smi_q  <= cmd_we & cfg_smm_q;
      if (wr_en)  en_q  <= io_wdata;
      if (wr_gen) gen_q <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_b0_q  <= '0;
      cfg_b1_q  <= '0;
      cfg_dec_q <= 1'b0;
      cfg_smm_q <= 1'b0;
    end else if (cfg_we) begin
      unique case (cfg_addr)
        CFG_BASE_LO: cfg_b0_q  <= cfg_wdata[7:6];
        CFG_BASE_HI: cfg_b1_q  <= cfg_wdata;
        CFG_DEC_EN:  cfg_dec_q <= cfg_wdata[0];
        CFG_SMM:     cfg_smm_q <= cfg_wdata[1];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (cfg_addr)
      CFG_BASE_LO: cfg_rdata = {cfg_b0_q, 5'b0, 1'b1};
      CFG_BASE_HI: cfg_rdata = cfg_b1_q;
      CFG_DEC_EN:  cfg_rdata = {7'b0, cfg_dec_q};
      CFG_SMM:     cfg_rdata = {6'b0, cfg_smm_q, 1'b0};
      default:     cfg_rdata = 8'h00;
    endcase
  end

  always_comb begin
    unique case (win_sel)
      SEL_STS: win_rd = RD_W'(sts_q);
      SEL_EN:  win_rd = RD_W'(en_q);
      SEL_CTL: win_rd = RD_W'(ctl_q);
      SEL_TMR: win_rd = RD_W'(tmr_val);
      default: win_rd = '0;
    endcase
    if (io_addr == GPE_BASE)         gpe_rd = RD_W'(gsts_q);
    else if (io_addr == GPE_EN_ADDR) gpe_rd = RD_W'(gen_q);
    else                             gpe_rd = '0;
  end

  assign io_rdata = io_rd ? (win_rd | gpe_rd) : '0;
  assign smi      = smi_q;
endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_we,
  input logic [7:0]       cmd_data,
  input logic             pwrbtn_req,
  input logic [EVT_W-1:0] evt_req,
  input logic             sci,
  input logic             smi,
  input logic [EVT_W-1:0] sts_q,
  input logic [EVT_W-1:0] en_q,
  input logic [EVT_W-1:0] ctl_q,
  input logic [EVT_W-1:0] gsts_q,
  input logic [EVT_W-1:0] gen_q,
  input logic [TMR_W-1:0] tmr_val
);
  // R12
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (sts_q == '0 && en_q == '0 && ctl_q == '0 && gsts_q == '0 &&
             gen_q == '0 && !smi && !sci));

  // R11
  smi_cause_chk: assert property (@(posedge clk) disable iff (rst)
    smi |-> $past(cmd_we));

  // R7
  pwr_set_chk: assert property (@(posedge clk) disable iff (rst)
    pwrbtn_req |=> sts_q[PWR_BIT]);

  // R10
  mode_on_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data == CMD_MODE_ON) |=> ctl_q[0]);

  // R10
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data == CMD_MODE_OFF) |=> !ctl_q[0]);

  // R5
  sci_level_chk: assert property (@(posedge clk) disable iff (rst)
    ((sts_q & en_q & SCI_MASK) != '0 || (gsts_q[HP_BIT] && gen_q[HP_BIT])) |-> sci);

  // R8
  tmr_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> tmr_val == TMR_W'($past(tmr_val) + TMR_W'(1)));

  // R9
  tmr_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q[TMR_BIT] && !sts_q[TMR_BIT] && !evt_req[TMR_BIT]) |=> !sts_q[TMR_BIT]);
endmodule

bind pm_evt_regs pm_evt_regs_chk #(.TMR_W(TMR_W)) u_chk (.*);

// File: tb/sim_pm_evt_regs.sv
module sim_pm_evt_regs;
  localparam int TW = 8;
  localparam logic [15:0] BASE = 16'h1240;
  localparam logic [15:0] GPE  = 16'hAFE0;
  localparam logic [15:0] MASK = 16'h0521;

  logic clk = 0, rst = 1;
  logic io_valid = 0, io_we = 0;
  logic [15:0] io_addr = 0, io_wdata = 0;
  logic [31:0] io_rdata;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic cmd_we = 0;
  logic [7:0] cmd_data = 0;
  logic pwrbtn_req = 0, hp_req = 0;
  logic [15:0] evt_req = 0;
  logic sci, smi;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  pm_evt_regs #(.TMR_W(TW), .GPE_BASE(GPE)) u0 (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .pwrbtn_req(pwrbtn_req), .evt_req(evt_req), .hp_req(hp_req), .sci(sci), .smi(smi)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); io_valid = 1; io_we = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_valid = 0; io_we = 0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); io_valid = 1; io_we = 0; io_addr = a;
    #1 d = io_rdata;
    io_valid = 0;
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic cmd_wr(input logic [7:0] d, input bit smi_exp, input string req);
    @(negedge clk); cmd_we = 1; cmd_data = d;
    @(negedge clk); cmd_we = 0; #1;
    chk(smi == smi_exp, req, 32'(smi), 32'(smi_exp));
    @(negedge clk); #1;
    chk(smi == 1'b0, req, 32'(smi), 32'd0);
  endtask

  task automatic pulse_evt(input logic [15:0] v);
    @(negedge clk); evt_req = v;
    @(negedge clk); evt_req = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r, t1, t2;
    logic [7:0]  c;
    logic        exp_sci;
    repeat (3) @(negedge clk);
    rst = 0;

    // R12 reset state
    #1 chk(!sci && !smi, "R12 sci/smi after reset", {sci, smi}, 0);
    cfg_rd(8'h40, c); chk(c == 8'h01, "R2 cfg40 reset", c, 8'h01);
    cfg_rd(8'h80, c); chk(c == 8'h00, "R12 cfg80 reset", c, 0);

    // R1 decode off: write ignored
    cfg_wr(8'h40, 8'h7E); cfg_wr(8'h41, 8'h12);
    io_rd(BASE + 16'h2, r); chk(r == 0, "R1 read while decode off", r, 0);
    io_wr(BASE + 16'h2, 16'hFFFF);
    cfg_wr(8'h80, 8'hFF);
    io_rd(BASE + 16'h2, r); chk(r == 0, "R1 write while decode off ignored", r, 0);
    cfg_rd(8'h40, c); chk(c == 8'h41, "R2 cfg40 bit0 read-only", c, 8'h41);
    cfg_rd(8'h41, c); chk(c == 8'h12, "R2 cfg41 readback", c, 8'h12);
    cfg_rd(8'h80, c); chk(c == 8'h01, "R2 cfg80 bit0 only", c, 8'h01);
    cfg_rd(8'h33, c); chk(c == 8'h00, "R2 unused cfg byte", c, 0);

    // R3 / R1 register map and window edges
    io_wr(BASE + 16'h2, 16'h0120);
    io_rd(BASE + 16'h2, r); chk(r == 32'h0120, "R3 enable readback", r, 32'h0120);
    io_rd(BASE + 16'h6, r); chk(r == 0, "R3 unmapped offset", r, 0);
    io_rd(BASE + 16'h42, r); chk(r == 0, "R1 outside window read", r, 0);
    io_wr(BASE + 16'h42, 16'hFFFF);
    io_rd(BASE + 16'h2, r); chk(r == 32'h0120, "R1 outside window write", r, 32'h0120);
    io_wr(BASE + 16'h4, 16'h0C00);
    io_rd(BASE + 16'h4, r); chk(r == 32'h0C00, "R3 control readback", r, 32'h0C00);

    // R10 / R11 command port
    cmd_wr(8'hF1, 1'b0, "R11 smi off when not permitted");
    io_rd(BASE + 16'h4, r); chk(r == 32'h0C01, "R10 0xF1 sets mode", r, 32'h0C01);
    cfg_wr(8'h5B, 8'hFF);
    cfg_rd(8'h5B, c); chk(c == 8'h02, "R2 cfg5B bit1 only", c, 8'h02);
    cmd_wr(8'h55, 1'b1, "R11 smi pulse on any command");
    io_rd(BASE + 16'h4, r); chk(r == 32'h0C01, "R10 other value no effect", r, 32'h0C01);
    cmd_wr(8'hF0, 1'b1, "R11 smi pulse on 0xF0");
    io_rd(BASE + 16'h4, r); chk(r == 32'h0C00, "R10 0xF0 clears mode", r, 32'h0C00);
    @(negedge clk); cmd_we = 1; cmd_data = 8'hF1;
    io_valid = 1; io_we = 1; io_addr = BASE + 16'h4; io_wdata = 16'h0000;
    @(negedge clk); cmd_we = 0; io_valid = 0; io_we = 0;
    io_rd(BASE + 16'h4, r); chk(r == 32'h0001, "R10 command beats io write", r, 32'h1);

    // R5 / R7 exhaustive single-bit sweep, enable bit 0 excluded from arming noise by reading status
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        io_wr(BASE, 16'hFFFF);
        io_wr(BASE + 16'h2, 16'(1 << j));
        pulse_evt(16'(1 << i));
        io_rd(BASE, r);
        exp_sci = |(r[15:0] & 16'(1 << j) & MASK);
        chk(r[i] == 1'b1, "R7 generic event sets bit", r, 32'(1 << i));
        chk(sci == exp_sci, "R5 sci from status and enable", 32'(sci), 32'(exp_sci));
        if (i == j && MASK[i]) chk(sci == 1'b1, "R5 enabled class raises sci", 32'(sci), 1);
      end
    end
    io_wr(BASE + 16'h2, 16'h0000);
    io_wr(BASE, 16'hFFFF);
    io_rd(BASE, r); chk(r == 0, "R4 clear all", r, 0);

    // R4 selective clear and set-wins
    pulse_evt(16'h0420);
    io_wr(BASE, 16'h0020);
    io_rd(BASE, r); chk(r == 32'h0400, "R4 write-one clears only that bit", r, 32'h0400);
    io_wr(BASE, 16'h0000);
    io_rd(BASE, r); chk(r == 32'h0400, "R4 write zero no effect", r, 32'h0400);
    @(negedge clk); evt_req = 16'h0400; io_valid = 1; io_we = 1; io_addr = BASE; io_wdata = 16'h0400;
    @(negedge clk); evt_req = 0; io_valid = 0; io_we = 0;
    io_rd(BASE, r); chk(r == 32'h0400, "R4 set wins over clear", r, 32'h0400);
    io_wr(BASE, 16'hFFFF);

    // R7 power button
    io_wr(BASE + 16'h2, 16'h0100);
    @(negedge clk); pwrbtn_req = 1; @(negedge clk); pwrbtn_req = 0;
    io_rd(BASE, r); chk(r == 32'h0100, "R7 power button sets bit 8", r, 32'h0100);
    chk(sci == 1'b1, "R5 power button sci", 32'(sci), 1);
    io_wr(BASE, 16'h0100); #1;
    chk(sci == 1'b0, "R5 sci drops after clear", 32'(sci), 0);
    io_wr(BASE + 16'h2, 16'h0000);

    // R8 timer step and width
    io_rd(BASE + 16'h8, t1);
    repeat (4) @(negedge clk);
    io_rd(BASE + 16'h8, t2);
    chk(((t2 - t1) & 32'hFF) == 5, "R8 timer counts each clock", t2 - t1, 5);
    chk(t2[31:TW] == 0, "R3 timer zero-extended", t2, t2 & 32'hFF);

    // R9 disarmed then armed
    io_wr(BASE, 16'hFFFF);
    repeat (300) @(negedge clk);
    io_rd(BASE, r); chk(r[0] == 1'b0, "R9 no timer status when disarmed", r, 0);
    io_wr(BASE + 16'h2, 16'h0001);
    repeat (300) @(negedge clk);
    io_rd(BASE, r); chk(r[0] == 1'b1, "R9 timer status when armed", r, 1);
    chk(sci == 1'b1, "R5 timer sci", 32'(sci), 1);
    io_wr(BASE + 16'h2, 16'h0000);
    io_wr(BASE, 16'hFFFF);

    // R6 GPE hot-plug
    @(negedge clk); hp_req = 1; @(negedge clk); hp_req = 0;
    io_rd(GPE, r); chk(r == 32'h0002, "R6 hot-plug sets gpe bit1", r, 2);
    chk(sci == 1'b0, "R6 gpe masked", 32'(sci), 0);
    io_wr(GPE + 16'h2, 16'hFFFD); #1;
    chk(sci == 1'b0, "R5 only gpe bit1 counts", 32'(sci), 0);
    io_wr(GPE + 16'h2, 16'h0002); #1;
    chk(sci == 1'b1, "R5 gpe sci", 32'(sci), 1);
    io_rd(GPE + 16'h2, r); chk(r == 32'h0002, "R6 gpe enable readback", r, 2);
    io_wr(GPE, 16'h0002); #1;
    chk(sci == 1'b0, "R6 gpe w1c drops sci", 32'(sci), 0);

    // R12 mid-run reset
    io_wr(BASE + 16'h2, 16'h0100); pulse_evt(16'h0100);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0; #1;
    chk(!sci && !smi, "R12 outputs after reset", {sci, smi}, 0);
    cfg_rd(8'h41, c); chk(c == 0, "R12 cfg cleared", c, 0);
    cfg_wr(8'h40, 8'h40); cfg_wr(8'h41, 8'h12); cfg_wr(8'h80, 8'h01);
    io_rd(BASE, r);        chk(r == 0, "R12 status cleared", r, 0);
    io_rd(BASE + 16'h2, r); chk(r == 0, "R12 enable cleared", r, 0);
    io_rd(BASE + 16'h4, r); chk(r == 0, "R12 control cleared", r, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule